// File: doc/BRIEF.md
# Top-Bit Precomputed Unsigned Greater-Than Comparator

This block decides, for two unsigned operands C and D of a parameterised width, whether C is strictly greater than D. It returns a registered flag with a matching valid strobe. It is intended for a datapath where most operand pairs differ in their top bit. In that case the answer follows from the two most significant bits alone, and the lower part of the comparison does not need to switch.

On every accepted input the two top bits are always captured. A single XNOR of the incoming, unregistered top bits is formed ahead of the registers. It acts as the load enable for the registers that hold the remaining lower bits of both operands. When the top bits differ, those lower registers keep their old contents, and the registered top bit of C is taken as the answer. When the top bits agree, the lower registers load and a lower-bit magnitude chain decides the result.

A saturating counter reports how many accepted inputs skipped the lower-bit load. This gives a direct measure of how often the saving applied.

Top module: `gt_precomp_cmp`

## Requirements
- R1: When `in_valid` is high at a clock edge, `out_valid` is high after the second following edge. `out_gt` then equals 1 exactly when C > D as unsigned numbers. Back-to-back inputs each give their own result.
- R2: An accepted input with C's top bit 1 and D's top bit 0 gives `out_gt` = 1, whatever the lower bits are.
- R3: An accepted input with C's top bit 0 and D's top bit 1 gives `out_gt` = 0, whatever the lower bits are.
- R4: Equal operands give `out_gt` = 0.
- R5: The lower-bit operand registers load only on an accepted input whose incoming top bits are equal. `skip_count` rises by exactly one for each accepted input whose top bits differ. It does not change on idle cycles, even when the idle data have differing top bits.
- R6: `out_gt` is 0 in every cycle in which `out_valid` is 0.
- R7: During and right after a synchronous active-high reset, `out_valid`, `out_gt` and `skip_count` are all 0.
- R8: `skip_count` saturates at its all-ones value and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair is valid this cycle |
| op_c | input | WIDTH | Operand C, unsigned |
| op_d | input | WIDTH | Operand D, unsigned |
| out_valid | output | 1 | Result strobe, two cycles after `in_valid` |
| out_gt | output | 1 | 1 when C > D |
| skip_count | output | CNT_W | Saturating count of accepted inputs that skipped the lower-bit load |

## Verification
Directed pairs with differing top bits put the opposite extreme in the lower bits. This catches a result that wrongly consults the stale lower registers. Pairs with equal top bits cover equality, a difference in only the least significant bit, and lower halves at all-zeros or all-ones. These exercise the lower-bit chain and its tie handling. Random traffic, weighted so that both the skip and load paths occur, is interleaved with idle cycles that carry differing top bits. A second instance with a 3-bit counter is driven past its limit to separate saturation from wrap-around.

// File: rtl/gtc_pkg.sv
package gtc_pkg;

    localparam int DEF_WIDTH = 16;
    localparam int DEF_CNT_W = 16;

    typedef struct packed {
        logic c;
        logic d;
    } msb_pair_t;

    typedef enum logic [1:0] {
        DEC_TIE  = 2'b00,
        DEC_C_HI = 2'b01,
        DEC_D_HI = 2'b10
    } msb_dec_e;

    function automatic msb_dec_e classify(input msb_pair_t p);
        msb_dec_e r;
        if (p.c && !p.d)      r = DEC_C_HI;
        else if (!p.c && p.d) r = DEC_D_HI;
        else                  r = DEC_TIE;
        return r;
    endfunction

endpackage

// File: rtl/gtc_precompute.sv
module gtc_precompute
    import gtc_pkg::*;
(
    input  logic      in_valid,
    input  msb_pair_t msb_in,
    output logic      lower_load,
    output logic      skip_pulse
);
    logic top_match;

    always_comb begin
        top_match  = ~(msb_in.c ^ msb_in.d);
        lower_load = in_valid & top_match;
        skip_pulse = in_valid & ~top_match;
    end

endmodule

// File: rtl/gtc_opbank.sv
module gtc_opbank
    import gtc_pkg::*;
#(
    parameter int LW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          lower_load,
    input  msb_pair_t     msb_in,
    input  logic [LW-1:0] c_lo_in,
    input  logic [LW-1:0] d_lo_in,
    output msb_pair_t     msb_q,
    output logic [LW-1:0] c_lo_q,
    output logic [LW-1:0] d_lo_q,
    output logic          stage_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            msb_q       <= '0;
            stage_valid <= 1'b0;
        end else begin
            stage_valid <= in_valid;
            if (in_valid) msb_q <= msb_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_lo_q <= '0;
            d_lo_q <= '0;
        end else if (lower_load) begin
            c_lo_q <= c_lo_in;
            d_lo_q <= d_lo_in;
        end
    end

    assert_lower_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!in_valid || (msb_in.c != msb_in.d)) |=> ($stable(c_lo_q) && $stable(d_lo_q)));

endmodule

// File: rtl/gtc_lower_cmp.sv
module gtc_lower_cmp #(
    parameter int LW = 15
) (
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    output logic          a_gt_b
);
    logic [LW:0] gt_chain;

    assign gt_chain[0] = 1'b0;

    generate
        for (genvar i = 0; i < LW; i++) begin : g_bit
            logic bit_gt, bit_eq;
            assign bit_gt          = a[i] & ~b[i];
            assign bit_eq          = ~(a[i] ^ b[i]);
            assign gt_chain[i + 1] = bit_gt | (bit_eq & gt_chain[i]);
        end
    endgenerate

    assign a_gt_b = gt_chain[LW];

endmodule

// File: rtl/gtc_skip_counter.sv
module gtc_skip_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)                          count <= '0;
        else if (inc && count != CNT_MAX) count <= count + 1'b1;
    end

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(count));
    assert_step_one_R5: assert property (@(posedge clk) disable iff (rst)
        (inc && count != CNT_MAX) |=> (count == $past(count) + 1'b1));
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_MAX) |=> (count == CNT_MAX));

endmodule

// File: rtl/gt_precomp_cmp.sv
module gt_precomp_cmp
    import gtc_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH,
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] op_c,
    input  logic [WIDTH-1:0] op_d,
    output logic             out_valid,
    output logic             out_gt,
    output logic [CNT_W-1:0] skip_count
);
    localparam int LW = WIDTH - 1;

    msb_pair_t     msb_in, msb_q;
    logic          lower_load, skip_pulse, stage_valid, lo_gt, result;
    logic [LW-1:0] c_lo_q, d_lo_q;
    msb_dec_e      dec_q;

    assign msb_in.c = op_c[WIDTH-1];
    assign msb_in.d = op_d[WIDTH-1];

    gtc_precompute u_pre (
        .in_valid  (in_valid),
        .msb_in    (msb_in),
        .lower_load(lower_load),
        .skip_pulse(skip_pulse)
    );

    gtc_opbank #(.LW(LW)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .lower_load (lower_load),
        .msb_in     (msb_in),
        .c_lo_in    (op_c[LW-1:0]),
        .d_lo_in    (op_d[LW-1:0]),
        .msb_q      (msb_q),
        .c_lo_q     (c_lo_q),
        .d_lo_q     (d_lo_q),
        .stage_valid(stage_valid)
    );

    gtc_lower_cmp #(.LW(LW)) u_lo (
        .a     (c_lo_q),
        .b     (d_lo_q),
        .a_gt_b(lo_gt)
    );

    gtc_skip_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .inc  (skip_pulse),
        .count(skip_count)
    );

    always_comb begin
        dec_q = classify(msb_q);
        unique case (dec_q)
            DEC_C_HI: result = 1'b1;
            DEC_D_HI: result = 1'b0;
            default:  result = lo_gt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_gt    <= 1'b0;
        end else begin
            out_valid <= stage_valid;
            out_gt    <= stage_valid & result;
        end
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);
    assert_c_top_wins_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_c[WIDTH-1] && !op_d[WIDTH-1]) |-> ##2 out_gt);
    assert_d_top_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_c[WIDTH-1] && op_d[WIDTH-1]) |-> ##2 !out_gt);
    assert_equal_low_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_c == op_d) |-> ##2 !out_gt);
    assert_quiet_flag_R6: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_gt);

endmodule

// File: tb/gt_precomp_cmp_tb.sv
module gt_precomp_cmp_tb;
    localparam int W = 16;
    localparam int SAT_W = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, in_valid;
    logic [W-1:0] op_c, op_d;
    logic out_valid, out_gt, sat_valid, sat_gt;
    logic [15:0] skip_count;
    logic [SAT_W-1:0] sat_count;

    gt_precomp_cmp #(.WIDTH(W), .CNT_W(16)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_c(op_c), .op_d(op_d),
        .out_valid(out_valid), .out_gt(out_gt), .skip_count(skip_count)
    );

    gt_precomp_cmp #(.WIDTH(W), .CNT_W(SAT_W)) u_sat (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_c(op_c), .op_d(op_d),
        .out_valid(sat_valid), .out_gt(sat_gt), .skip_count(sat_count)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference pipeline: slot 0 = just driven, slot 1 = due at next sample
    logic  p0_v = 0, p1_v = 0, p0_gt = 0, p1_gt = 0;
    string p0_tag = "R1", p1_tag = "R1";
    int    exp_cnt = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic v, input logic [W-1:0] c, input logic [W-1:0] d);
        int sat_exp;
        @(negedge clk);
        chk("R1 out_valid", int'(out_valid), int'(p1_v));
        if (p1_v) chk(p1_tag, int'(out_gt), int'(p1_gt));
        else      chk("R6 out_gt idle", int'(out_gt), 0);
        chk("R5 skip_count", int'(skip_count), exp_cnt);
        sat_exp = (exp_cnt > 7) ? 7 : exp_cnt;
        chk("R8 saturated count", int'(sat_count), sat_exp);
        chk("R1 second instance result", int'(sat_gt), int'(out_gt));
        p1_v = p0_v; p1_gt = p0_gt; p1_tag = p0_tag;
        in_valid = v; op_c = c; op_d = d;
        p0_v  = v;
        p0_gt = v && (c > d);
        if (c[W-1] && !d[W-1])      p0_tag = "R2";
        else if (!c[W-1] && d[W-1]) p0_tag = "R3";
        else if (c == d)            p0_tag = "R4";
        else                        p0_tag = "R1";
        if (v && (c[W-1] != d[W-1])) exp_cnt++;
    endtask

    localparam logic [W-1:0] TOP  = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] LOWS = {1'b0, {(W-1){1'b1}}};

    initial begin
        rst = 1; in_valid = 0; op_c = '0; op_d = '0;
        repeat (3) @(negedge clk);
        // R7: reset state
        chk("R7 out_valid", int'(out_valid), 0);
        chk("R7 out_gt", int'(out_gt), 0);
        chk("R7 skip_count", int'(skip_count), 0);
        rst = 0;

        // R2/R3: lower bits set to the misleading extreme
        cycle(1, TOP, LOWS);
        cycle(1, TOP, TOP | LOWS);
        cycle(1, LOWS, TOP);
        cycle(1, '0, TOP);
        // equal-top cases right after stale lower registers
        cycle(1, 16'h0001, 16'h0000);
        cycle(1, 16'h8000, 16'h8001);
        // R4: equal operands
        cycle(1, '0, '0);
        cycle(1, '1, '1);
        cycle(1, 16'h5A5A, 16'h5A5A);
        // R5/R6: idle cycles carrying differing top bits
        cycle(0, TOP, '0);
        cycle(0, '0, TOP);
        cycle(1, LOWS, '0);
        cycle(0, TOP | 16'h1234, 16'h0FFF);
        cycle(1, TOP | 16'h0002, TOP | 16'h0001);

        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] c, d;
            logic v;
            c = W'($urandom);
            d = W'($urandom);
            if ($urandom_range(0, 2) == 0) d[W-1] = c[W-1];
            if ($urandom_range(0, 9) == 0) d = c;
            v = ($urandom_range(0, 4) != 0);
            cycle(v, c, d);
        end

        cycle(0, '0, '0);
        cycle(0, '0, '0);
        cycle(0, '0, '0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule